// File: doc/BRIEF.md
# Multi-cycle 32-bit integer core

A small integer processor that executes one instruction every two clock cycles: one cycle fetches a 32-bit word from the instruction port into an instruction register, and the next cycle decodes it, runs it and writes the result back. It has 32 general registers. The instruction set covers immediate and register ALU operations, upper-immediate loads, PC-relative upper immediates, an indirect jump-and-link, eight conditional branches and word loads and stores. Four of the branches compare a register against a small unsigned constant, not against a second register. A dedicated opcode moves single bytes through a valid/ready output channel and a valid/ready input channel.

Both memories are read combinationally: the core drives an address and expects the word back in the same cycle. Data stores take effect on the clock edge that ends the execute cycle. When the core sees an unknown opcode, or an unknown function code in the groups that define one, it raises a sticky flag and stops for good. Only reset restarts it.

Top module: `tiny_int_core`

## Requirements
- R1: While reset is low, and until the first instruction retires, the instruction address is 0, the illegal flag is low, and no data-memory write, byte output or byte input request is active.
- R2: Opcode 0010011 selects immediate ALU operations by funct3 [14:12]: 000 add, 001 shift left, 100 xor, 101 arithmetic shift right, 111 and. The 12-bit immediate [31:20] is sign-extended, and shift amounts come from [24:20].
- R3: Opcode 0110011 gives register add (funct3 000), subtract (010) and xor (100). Opcode 0110111 writes {[31:12],12'b0} to rd [11:7]. Opcode 0010111 writes pc plus that value.
- R4: Register 0 reads as zero, and writes to it are discarded.
- R5: Opcode 1100011 with funct3 000/001/100/101 branches on rs1 [19:15] vs rs2 [24:20]: equal, not equal, signed less-than, signed greater-or-equal. A taken branch goes to pc + {[31],[7],[30:25],[11:8],0} sign-extended, and backward offsets are allowed. Otherwise the next pc is pc+4.
- R6: Branch funct3 010/011/110/111 compares rs1 with the zero-extended 5-bit value [24:20]: equal, not equal, signed less-than, signed greater-than.
- R7: Opcode 0000011 loads the word at rs1 + sign-extended [31:20]. Opcode 0100011 stores rs2 to rs1 + sign-extended {[31:25],[11:7]}. Addresses are byte addresses.
- R8: Opcode 1100111 writes pc+4 to rd and continues at rs1 + sign-extended [31:20].
- R9: Opcode 1111111 with funct3 000 presents rs1[7:0] with out_valid_o. The core stalls, holding the data and the pc, until out_ready_i is high.
- R10: Opcode 1111111 with funct3 001 raises in_ready_o and stalls until in_valid_i. It then writes in_data_i zero-extended to 32 bits into rd.
- R11: Any other opcode, or an unlisted funct3 under opcodes 0010011, 0110011 or 1111111, sets illegal_o. From then on the pc freezes and no memory or byte transfer takes place. Only reset clears the flag.
- R12: An instruction that is not stalled takes exactly two cycles, so the instruction address moves from 0 to 4 two clock edges after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | 32 | Instruction byte address (pc) |
| imem_data_i | input | 32 | Instruction word, combinational read |
| dmem_addr_o | output | 32 | Data byte address |
| dmem_we_o | output | 1 | Data write strobe |
| dmem_re_o | output | 1 | Data read strobe |
| dmem_wdata_o | output | 32 | Data write word |
| dmem_rdata_i | input | 32 | Data read word, combinational |
| out_data_o | output | 8 | Output byte |
| out_valid_o | output | 1 | Output byte valid |
| out_ready_i | input | 1 | Output byte accepted |
| in_data_i | input | 8 | Input byte |
| in_valid_i | input | 1 | Input byte present |
| in_ready_o | output | 1 | Core waiting for an input byte |
| illegal_o | output | 1 | Sticky illegal-instruction flag |

## Verification
A wrong register value stays hidden until some instruction stores it or sends it out. The bench therefore ends every program by storing or emitting the registers it touched, and checks each word in full. A bad branch decision or offset shows up within two cycles as a wrong instruction address, and later as a flag bit that should not be in the result word. A broken stall or halt shows up in the first cycle after the event as a moving instruction address or a dropped valid while the partner is not ready. A decode that wrongly accepts an illegal word shows up as a store that lands in memory.

// File: rtl/core_pkg.sv
package core_pkg;
  parameter int unsigned XLEN = 32;
  parameter int unsigned NREG = 32;
  localparam int unsigned RAW = $clog2(NREG);

  localparam logic [6:0] OPC_IMM   = 7'b0010011;
  localparam logic [6:0] OPC_REG   = 7'b0110011;
  localparam logic [6:0] OPC_BR    = 7'b1100011;
  localparam logic [6:0] OPC_JALR  = 7'b1100111;
  localparam logic [6:0] OPC_AUIPC = 7'b0010111;
  localparam logic [6:0] OPC_LUI   = 7'b0110111;
  localparam logic [6:0] OPC_LOAD  = 7'b0000011;
  localparam logic [6:0] OPC_STORE = 7'b0100011;
  localparam logic [6:0] OPC_IO    = 7'b1111111;

  typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_XOR, ALU_AND, ALU_SLL, ALU_SRA} alu_op_e;
  typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_HALT} state_e;

  typedef struct packed {
    logic [6:0]      opcode;
    logic [2:0]      funct3;
    logic [RAW-1:0]  rd;
    logic [RAW-1:0]  rs1;
    logic [RAW-1:0]  rs2;
    logic [XLEN-1:0] imm_i;
    logic [XLEN-1:0] imm_s;
    logic [XLEN-1:0] imm_b;
    logic [XLEN-1:0] imm_u;
    logic            legal;
  } dec_t;
endpackage

// File: rtl/core_decode.sv
module core_decode
  import core_pkg::*;
(
  input  logic [31:0] ir_i,
  output dec_t        dec_o
);
  always_comb begin
    dec_o.opcode = ir_i[6:0];
    dec_o.funct3 = ir_i[14:12];
    dec_o.rd     = ir_i[11:7];
    dec_o.rs1    = ir_i[19:15];
    dec_o.rs2    = ir_i[24:20];
    dec_o.imm_i  = XLEN'($signed(ir_i[31:20]));
    dec_o.imm_s  = XLEN'($signed({ir_i[31:25], ir_i[11:7]}));
    dec_o.imm_b  = XLEN'($signed({ir_i[31], ir_i[7], ir_i[30:25], ir_i[11:8], 1'b0}));
    dec_o.imm_u  = XLEN'($signed({ir_i[31:12], 12'b0}));
    unique case (ir_i[6:0])
      OPC_IMM:  dec_o.legal = ir_i[14:12] inside {3'b000, 3'b001, 3'b100, 3'b101, 3'b111};
      OPC_REG:  dec_o.legal = ir_i[14:12] inside {3'b000, 3'b010, 3'b100};
      OPC_IO:   dec_o.legal = ir_i[14:12] inside {3'b000, 3'b001};
      OPC_BR, OPC_JALR, OPC_AUIPC, OPC_LUI, OPC_LOAD, OPC_STORE:
                dec_o.legal = 1'b1;
      default:  dec_o.legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
(
  input  alu_op_e         op_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] y_o
);
  localparam int unsigned SHW = $clog2(XLEN);

  always_comb begin
    unique case (op_i)
      ALU_SUB: y_o = a_i - b_i;
      ALU_XOR: y_o = a_i ^ b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_SLL: y_o = a_i << b_i[SHW-1:0];
      ALU_SRA: y_o = $signed(a_i) >>> b_i[SHW-1:0];
      default: y_o = a_i + b_i;
    endcase
  end
endmodule

// File: rtl/core_branch.sv
module core_branch
  import core_pkg::*;
(
  input  logic [2:0]      funct3_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic [4:0]      imm5_i,
  output logic            take_o
);
  logic [XLEN-1:0] rhs;
  logic eq, lt, gt;

  // funct3[1] picks the small unsigned constant as comparand
  assign rhs = funct3_i[1] ? XLEN'(imm5_i) : b_i;
  assign eq  = (a_i == rhs);
  assign lt  = $signed(a_i) < $signed(rhs);
  assign gt  = $signed(a_i) > $signed(rhs);

  always_comb begin
    unique case (funct3_i)
      3'b000, 3'b010: take_o = eq;
      3'b001, 3'b011: take_o = !eq;
      3'b100, 3'b110: take_o = lt;
      3'b101:         take_o = !lt;
      default:        take_o = gt;
    endcase
  end
endmodule

// File: rtl/core_regfile.sv
module core_regfile #(
  parameter int unsigned NR = 32,
  parameter int unsigned W  = 32,
  localparam int unsigned AW = $clog2(NR)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [W-1:0]  rdata_a_o,
  output logic [W-1:0]  rdata_b_o
);
  logic [W-1:0] regs [NR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NR; i++) regs[i] <= '0;
    end else if (we_i && waddr_i != '0) begin
      regs[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = regs[raddr_a_i];
  assign rdata_b_o = regs[raddr_b_i];
endmodule

// File: rtl/tiny_int_core.sv
module tiny_int_core
  import core_pkg::*;
#(
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  output logic [XLEN-1:0] imem_addr_o,
  input  logic [31:0]     imem_data_i,
  output logic [XLEN-1:0] dmem_addr_o,
  output logic            dmem_we_o,
  output logic            dmem_re_o,
  output logic [XLEN-1:0] dmem_wdata_o,
  input  logic [XLEN-1:0] dmem_rdata_i,
  output logic [7:0]      out_data_o,
  output logic            out_valid_o,
  input  logic            out_ready_i,
  input  logic [7:0]      in_data_i,
  input  logic            in_valid_i,
  output logic            in_ready_o,
  output logic            illegal_o
);
  state_e          state_q;
  logic [XLEN-1:0] pc_q;
  logic [31:0]     ir_q;
  logic            illegal_q;
  dec_t            dec;
  logic [XLEN-1:0] rs1v, rs2v, alu_b, alu_y, agen, pc_inc, next_pc, wb_data;
  alu_op_e         alu_op;
  logic            take, wb_en, stall, exec;

  core_decode u_dec (.ir_i(ir_q), .dec_o(dec));

  core_regfile #(.NR(NREG), .W(XLEN)) u_rf (
    .clk_i, .rst_ni,
    .we_i(wb_en && !stall), .waddr_i(dec.rd), .wdata_i(wb_data),
    .raddr_a_i(dec.rs1), .raddr_b_i(dec.rs2),
    .rdata_a_o(rs1v), .rdata_b_o(rs2v)
  );

  core_alu u_alu (.op_i(alu_op), .a_i(rs1v), .b_i(alu_b), .y_o(alu_y));

  core_branch u_br (
    .funct3_i(dec.funct3), .a_i(rs1v), .b_i(rs2v), .imm5_i(dec.rs2), .take_o(take)
  );

  assign exec   = (state_q == ST_EXEC) && dec.legal;
  assign pc_inc = pc_q + XLEN'(4);
  assign agen   = rs1v + ((dec.opcode == OPC_STORE) ? dec.imm_s : dec.imm_i);

  always_comb begin
    alu_op = ALU_ADD;
    alu_b  = (dec.opcode == OPC_REG) ? rs2v : dec.imm_i;
    unique case (dec.funct3)
      3'b001: begin alu_op = ALU_SLL; alu_b = XLEN'(dec.rs2); end
      3'b010: alu_op = ALU_SUB;
      3'b100: alu_op = ALU_XOR;
      3'b101: begin alu_op = ALU_SRA; alu_b = XLEN'(dec.rs2); end
      3'b111: alu_op = ALU_AND;
      default: alu_op = ALU_ADD;
    endcase
  end

  always_comb begin
    wb_en       = 1'b0;
    wb_data     = alu_y;
    next_pc     = pc_inc;
    stall       = 1'b0;
    dmem_we_o   = 1'b0;
    dmem_re_o   = 1'b0;
    out_valid_o = 1'b0;
    in_ready_o  = 1'b0;
    if (exec) begin
      unique case (dec.opcode)
        OPC_IMM, OPC_REG: wb_en = 1'b1;
        OPC_LUI:   begin wb_en = 1'b1; wb_data = dec.imm_u; end
        OPC_AUIPC: begin wb_en = 1'b1; wb_data = pc_q + dec.imm_u; end
        OPC_JALR:  begin wb_en = 1'b1; wb_data = pc_inc; next_pc = agen; end
        OPC_BR:    if (take) next_pc = pc_q + dec.imm_b;
        OPC_LOAD:  begin dmem_re_o = 1'b1; wb_en = 1'b1; wb_data = dmem_rdata_i; end
        OPC_STORE: dmem_we_o = 1'b1;
        OPC_IO: begin
          if (!dec.funct3[0]) begin
            out_valid_o = 1'b1;
            stall       = !out_ready_i;
          end else begin
            in_ready_o = 1'b1;
            stall      = !in_valid_i;
            wb_en      = in_valid_i;
            wb_data    = XLEN'(in_data_i);
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_FETCH;
      pc_q      <= RESET_PC;
      ir_q      <= '0;
      illegal_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_FETCH: begin
          ir_q    <= imem_data_i;
          state_q <= ST_EXEC;
        end
        ST_EXEC: begin
          if (!dec.legal) begin
            illegal_q <= 1'b1;
            state_q   <= ST_HALT;
          end else if (!stall) begin
            pc_q    <= next_pc;
            state_q <= ST_FETCH;
          end
        end
        default: state_q <= ST_HALT;
      endcase
    end
  end

  assign imem_addr_o  = pc_q;
  assign dmem_addr_o  = agen;
  assign dmem_wdata_o = rs2v;
  assign out_data_o   = rs1v[7:0];
  assign illegal_o    = illegal_q;

  AST_ILLEGAL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> illegal_o); // R11
  AST_HALT_PC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |=> $stable(imem_addr_o)); // R11
  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !(dmem_we_o || dmem_re_o || out_valid_o || in_ready_o)); // R11
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_data_o) && $stable(imem_addr_o))); // R9
  AST_IN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_ready_o && !in_valid_i) |=> (in_ready_o && $stable(imem_addr_o))); // R10
  AST_ONE_SIDE_EFFECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({dmem_we_o, dmem_re_o, out_valid_o, in_ready_o})); // R7
endmodule

// File: tb/tiny_int_core_tb.sv
`timescale 1ns/1ps
module tiny_int_core_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_we, dmem_re;
  logic [7:0]  out_data, in_data;
  logic        out_valid, out_ready, in_valid, in_ready, illegal;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  logic [7:0]  obuf [8];
  int          ocnt;
  int          checks = 0;
  int          errors = 0;

  always #2 clk = ~clk;

  tiny_int_core u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .imem_addr_o(imem_addr), .imem_data_i(imem_data),
    .dmem_addr_o(dmem_addr), .dmem_we_o(dmem_we), .dmem_re_o(dmem_re),
    .dmem_wdata_o(dmem_wdata), .dmem_rdata_i(dmem_rdata),
    .out_data_o(out_data), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .in_data_i(in_data), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .illegal_o(illegal)
  );

  assign imem_data  = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) dmem[i] <= '0;
      ocnt <= 0;
    end else begin
      if (dmem_we) dmem[dmem_addr[7:2]] <= dmem_wdata;
      if (out_valid && out_ready) begin
        obuf[ocnt[2:0]] <= out_data;
        ocnt <= ocnt + 1;
      end
    end
  end

  // encoders
  function automatic logic [31:0] e_i(logic [6:0] op, int rd, logic [2:0] f3, int rs1, int imm);
    logic [11:0] im = 12'(imm);
    return {im, 5'(rs1), f3, 5'(rd), op};
  endfunction
  function automatic logic [31:0] e_r(logic [2:0] f3, int rd, int rs1, int rs2);
    return {7'b0, 5'(rs2), 5'(rs1), f3, 5'(rd), 7'b0110011};
  endfunction
  function automatic logic [31:0] e_s(int rs2, int rs1, int imm);
    logic [11:0] im = 12'(imm);
    return {im[11:5], 5'(rs2), 5'(rs1), 3'b010, im[4:0], 7'b0100011};
  endfunction
  function automatic logic [31:0] e_b(logic [2:0] f3, int rs1, int rs2, int off);
    logic [12:0] o = 13'(off);
    return {o[12], o[10:5], 5'(rs2), 5'(rs1), f3, o[4:1], o[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] e_u(logic [6:0] op, int rd, int imm20);
    return {20'(imm20), 5'(rd), op};
  endfunction

  localparam logic [6:0] IMM = 7'b0010011, LUI = 7'b0110111, AUI = 7'b0010111;
  localparam logic [6:0] LD = 7'b0000011, JR = 7'b1100111, IO = 7'b1111111;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_imem();
    for (int i = 0; i < 64; i++) imem[i] = e_b(3'b000, 0, 0, 0);
  endtask

  task automatic run(int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; out_ready = 1'b0; in_valid = 1'b0; in_data = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    clear_imem();
    imem[0] = e_i(IMM, 1, 3'b000, 0, 1);
    @(negedge clk);
    rst_n = 1'b0; out_ready = 1'b0; in_valid = 1'b0; in_data = '0;
    @(negedge clk);
    chk("R1 pc in reset", imem_addr, 32'h0);
    chk("R1 illegal in reset", {31'b0, illegal}, 32'h0);
    chk("R1 strobes in reset", {28'b0, dmem_we, out_valid, in_ready, dmem_re}, 32'h0);
    rst_n = 1'b1;
    run(1);
    chk("R12 pc after one edge", imem_addr, 32'h0);
    run(1);
    chk("R12 pc after two edges", imem_addr, 32'h4);
  endtask

  task automatic t_alu_imm();
    clear_imem();
    imem[0] = e_i(IMM, 1, 3'b000, 0, -5);
    imem[1] = e_i(IMM, 2, 3'b001, 1, 3);
    imem[2] = e_i(IMM, 3, 3'b101, 1, 1);
    imem[3] = e_i(IMM, 4, 3'b100, 1, 'h0F0);
    imem[4] = e_i(IMM, 5, 3'b111, 1, 'h7FF);
    imem[5] = e_i(IMM, 0, 3'b000, 0, 5);
    imem[6] = e_i(IMM, 6, 3'b100, 0, 3);
    for (int k = 0; k < 6; k++) imem[7+k] = e_s(k + 1, 0, 4 * k);
    do_reset();
    run(34);
    chk("R2 addi negative", dmem[0], 32'hFFFF_FFFB);
    chk("R2 slli", dmem[1], 32'hFFFF_FFD8);
    chk("R2 srai arithmetic", dmem[2], 32'hFFFF_FFFD);
    chk("R2 xori", dmem[3], 32'hFFFF_FF0B);
    chk("R2 andi", dmem[4], 32'h0000_07FB);
    chk("R4 x0 ignores write", dmem[5], 32'h3);
  endtask

  task automatic t_alu_reg();
    clear_imem();
    imem[0] = e_u(LUI, 1, 'h12345);
    imem[1] = e_i(IMM, 2, 3'b000, 0, 'h678);
    imem[2] = e_r(3'b000, 3, 1, 2);
    imem[3] = e_r(3'b010, 4, 2, 1);
    imem[4] = e_r(3'b100, 5, 1, 2);
    imem[5] = e_u(AUI, 6, 'h1);
    imem[6] = e_u(LUI, 7, 'hFFFFF);
    for (int k = 0; k < 5; k++) imem[7+k] = e_s(k + 3, 0, 4 * k);
    do_reset();
    run(30);
    chk("R3 add", dmem[0], 32'h1234_5678);
    chk("R3 sub", dmem[1], 32'hEDCB_B678);
    chk("R3 xor", dmem[2], 32'h1234_5678);
    chk("R3 auipc", dmem[3], 32'h0000_1014);
    chk("R3 lui top bits", dmem[4], 32'hFFFF_F000);
  endtask

  task automatic t_branch();
    logic [2:0] f3 [11];
    int         r2 [11];
    f3 = '{3'b000, 3'b001, 3'b100, 3'b101, 3'b010, 3'b011, 3'b110, 3'b111, 3'b111, 3'b110, 3'b101};
    r2 = '{2, 2, 2, 2, 4, 4, 1, 3, 4, 31, 2};
    clear_imem();
    imem[0] = e_i(IMM, 1, 3'b000, 0, -3);
    imem[1] = e_i(IMM, 2, 3'b000, 0, 4);
    for (int k = 0; k < 11; k++) begin
      // k4,k5,k7,k8 and the final bge compare x2; the rest compare x1
      imem[2+2*k] = e_b(f3[k], (k == 4 || k == 5 || k == 7 || k == 8 || k == 10) ? 2 : 1, r2[k], 8);
      imem[3+2*k] = e_i(IMM, 5, 3'b100, 5, 1 << k);
    end
    imem[24] = e_s(5, 0, 0);
    imem[25] = e_i(IMM, 6, 3'b000, 6, 1);
    imem[26] = e_b(3'b110, 6, 3, -4);
    imem[27] = e_s(6, 0, 4);
    do_reset();
    run(100);
    // not taken: beq(k0) bge(k3) bnei(k5) bgti equal(k8)
    chk("R5 R6 branch outcome mask", dmem[0], 32'h0000_0129);
    chk("R5 backward branch loop count", dmem[1], 32'h3);
  endtask

  task automatic t_mem_jalr();
    clear_imem();
    imem[0]  = e_i(IMM, 1, 3'b000, 0, 'h55);
    imem[1]  = e_i(IMM, 2, 3'b000, 0, 40);
    imem[2]  = e_s(1, 2, -8);
    imem[3]  = e_i(LD, 3, 3'b010, 2, -8);
    imem[4]  = e_i(IMM, 3, 3'b000, 3, 1);
    imem[5]  = e_s(3, 0, 36);
    imem[6]  = e_i(JR, 4, 3'b000, 2, -4);
    imem[7]  = e_i(IMM, 6, 3'b000, 0, 1);
    imem[8]  = e_i(IMM, 6, 3'b000, 0, 2);
    imem[9]  = e_s(4, 0, 40);
    imem[10] = e_s(6, 0, 44);
    do_reset();
    run(30);
    chk("R7 store negative offset", dmem[8], 32'h55);
    chk("R7 load then add", dmem[9], 32'h56);
    chk("R8 link value", dmem[10], 32'd28);
    chk("R8 jump skipped body", dmem[11], 32'h0);
  endtask

  task automatic t_io();
    clear_imem();
    imem[0] = e_i(IMM, 1, 3'b000, 0, 'h1A5);
    imem[1] = e_i(IO, 0, 3'b000, 1, 0);
    imem[2] = e_i(IO, 2, 3'b001, 0, 0);
    imem[3] = e_i(IO, 0, 3'b000, 2, 0);
    imem[4] = e_s(2, 0, 0);
    do_reset();
    run(6);
    chk("R9 out valid while not ready", {31'b0, out_valid}, 32'h1);
    chk("R9 out byte", {24'b0, out_data}, 32'hA5);
    chk("R9 pc held in stall", imem_addr, 32'h4);
    out_ready = 1'b1;
    run(7);
    chk("R9 one byte taken", ocnt, 1);
    chk("R9 byte value", {24'b0, obuf[0]}, 32'hA5);
    chk("R10 in ready while no data", {31'b0, in_ready}, 32'h1);
    chk("R10 pc held in stall", imem_addr, 32'h8);
    in_data = 8'hFC;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    run(10);
    chk("R10 read byte echoed", {24'b0, obuf[1]}, 32'hFC);
    chk("R10 byte zero-extended", dmem[0], 32'h0000_00FC);
  endtask

  task automatic t_illegal();
    clear_imem();
    imem[0] = e_i(IMM, 1, 3'b000, 0, 7);
    imem[1] = {7'b0000000, 5'd2, 5'd1, 3'b000, 5'd3, 7'b1010011};
    imem[2] = e_s(1, 0, 0);
    do_reset();
    run(20);
    chk("R11 unknown opcode flagged", {31'b0, illegal}, 32'h1);
    chk("R11 pc frozen", imem_addr, 32'h4);
    chk("R11 no store after halt", dmem[0], 32'h0);
    clear_imem();
    imem[0] = e_r(3'b001, 1, 0, 0);
    do_reset();
    @(negedge clk);
    chk("R11 reset clears flag", {31'b0, illegal}, 32'h0);
    run(10);
    chk("R11 register funct3 001 flagged", {31'b0, illegal}, 32'h1);
    clear_imem();
    imem[0] = e_i(IMM, 1, 3'b010, 0, 1);
    imem[1] = e_s(1, 0, 0);
    do_reset();
    run(10);
    chk("R11 immediate funct3 010 flagged", {31'b0, illegal}, 32'h1);
    chk("R11 immediate funct3 010 pc", imem_addr, 32'h0);
  endtask

  initial begin
    out_ready = 1'b0; in_valid = 1'b0; in_data = '0;
    t_reset();
    t_alu_imm();
    t_alu_reg();
    t_branch();
    t_mem_jalr();
    t_io();
    t_illegal();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule